// File: doc/BRIEF.md
# Interrupt Request Aggregator

The block gathers up to 32 interrupt sources into one request line for a processor. Each source is fixed at build time as level-sensitive or edge-sensitive. Captured requests are held in a status word and filtered by an enable word. Software sees the result through a small register window on a word-addressed 32-bit read/write strobe bus. That window shows which requests are pending and the index of the lowest-numbered pending source.

Software clears captured requests by writing a mask. It can set or clear enable bits with a single write, with no read-modify-write. A two-bit master control register holds two bits. Bit 0 lets the request line drive out. Bit 1 lets hardware capture sources into the status word. While capture is off, software may load the status word itself to raise interrupts from code.

Top module: `irq_hub`

## Requirements
- R1: The word index is bus_addr shifted right by 2, and the low two address bits are ignored. Index 0 is status, 2 is enable and 7 is master control. Each of these reads back its stored value, zero-extended. Master control keeps only bits [1:0].
- R2: Index 1 reads the pending word, which is always status AND enable.
- R3: Index 6 reads the index of the lowest-numbered pending bit. It reads 0xFFFFFFFF when nothing is pending.
- R4: irq_out is 1 exactly when master bit 0 is 1 and at least one pending bit is set.
- R5: Sources are captured into status only in cycles where the stored master bit 1 is already 1. A write to master control affects capture from the next cycle.
- R6: EDGE_SEL bit i = 0 makes source i level-sensitive, so its status bit is set in every cycle the source is high. EDGE_SEL bit i = 1 makes source i edge-sensitive, so its status bit is set only in a cycle where the source is 1 and was 0 in the previous cycle.
- R7: A write to index 3 clears every status bit whose written bit is 1. A capture in the same cycle still sets its bit.
- R8: A write to index 4 ORs the data into enable. A write to index 5 clears the enable bits that are 1 in the data. A write to index 2 loads enable.
- R9: A write to index 0 loads status only while master bit 1 is 0, and is ignored otherwise. Writes to indices 1 and 6 change nothing. Indices 3, 4 and 5 always read 0.
- R10: Reads at indices 8 and above return 0, and writes there change nothing.
- R11: After reset, status, enable and master control are 0, the vector reads 0xFFFFFFFF and irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | NSRC | Interrupt sources, synchronous to clk |
| irq_out | output | 1 | Request to the processor |

## Verification
The assertions take two things for granted. The sources are already synchronous to clk. A write strobe carries a single register operation per cycle, so an acknowledge and a status load never meet in one cycle. The stimulus changes sources and bus signals only on the falling edge and issues one bus operation per step. It uses an edge configuration that splits the sources into a level half and an edge half. Sources are held high across acknowledges so that level re-capture and edge non-recapture both appear.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC = 32,
  parameter int AW = 8,
  parameter logic [NSRC-1:0] EDGE_SEL = NSRC'(32'hFFFF_0000)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out
);
  localparam int IX_STAT = 0, IX_PEND = 1, IX_EN = 2, IX_ACK = 3;
  localparam int IX_SET = 4, IX_CLR = 5, IX_VEC = 6, IX_MST = 7;

  logic [NSRC-1:0] stat_q, en_q, src_q, pend, cap, wd;
  logic [1:0]      mst_q;
  logic [31:0]     vec;
  int              wsel;

  assign wsel = int'(bus_addr[AW-1:2]);
  assign wd   = bus_wdata[NSRC-1:0];
  assign pend = stat_q & en_q;
  assign cap  = mst_q[1] ? ((src_in & ~EDGE_SEL) | (src_in & ~src_q & EDGE_SEL)) : '0;
  assign irq_out = mst_q[0] && (|pend);

  always_comb begin
    vec = '1;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) vec = 32'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      src_q  <= '0;
      mst_q  <= '0;
    end else begin
      src_q <= src_in;
      if (bus_we && wsel == IX_STAT && !mst_q[1]) stat_q <= wd;
      else if (bus_we && wsel == IX_ACK)          stat_q <= (stat_q & ~wd) | cap;
      else                                        stat_q <= stat_q | cap;
      if (bus_we && wsel == IX_EN)  en_q <= wd;
      if (bus_we && wsel == IX_SET) en_q <= en_q | wd;
      if (bus_we && wsel == IX_CLR) en_q <= en_q & ~wd;
      if (bus_we && wsel == IX_MST) mst_q <= bus_wdata[1:0];
    end
  end

  always_comb begin
    case (wsel)
      IX_STAT: bus_rdata = 32'(stat_q);
      IX_PEND: bus_rdata = 32'(pend);
      IX_EN:   bus_rdata = 32'(en_q);
      IX_VEC:  bus_rdata = vec;
      IX_MST:  bus_rdata = 32'(mst_q);
      default: bus_rdata = '0;
    endcase
  end

  // R7: acknowledged bits are gone next cycle unless recaptured
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wsel == IX_ACK && !mst_q[1]) |=> ((stat_q & $past(wd)) == '0));
  // R8: set and clear enable
  a_r8_set_en: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wsel == IX_SET) |=> ((en_q & $past(wd)) == $past(wd)));
  a_r8_clr_en: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wsel == IX_CLR) |=> ((en_q & $past(wd)) == '0));
  // R9: status writes blocked while capture is on, so status never loses bits
  a_r9_stat_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wsel == IX_STAT && mst_q[1]) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R6: a high level source is captured
  a_r6_level_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    mst_q[1] |=> ((stat_q & $past(src_in & ~EDGE_SEL)) == $past(src_in & ~EDGE_SEL)));
  // R5: with capture off and no bus write, status holds
  a_r5_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_q[1] && !bus_we) |=> $stable(stat_q));
  // R4: no pending, no request
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & en_q) == '0 |-> !irq_out);
  // R3: vector reads all ones when nothing pends
  a_r3_no_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel == IX_VEC && (stat_q & en_q) == '0) |-> bus_rdata == 32'hFFFF_FFFF);
endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
  localparam logic [31:0] EDGE = 32'hFFFF_0000;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, src_in = 0;
  logic        irq_out;
  int checks = 0, failures = 0;
  logic [31:0] m_stat = 0, m_en = 0, m_srcq = 0;
  logic [1:0]  m_mst = 0;

  irq_hub #(.NSRC(32), .AW(8), .EDGE_SEL(EDGE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out));

  always #2 clk = ~clk;

  function automatic logic [31:0] m_vec();
    for (int i = 0; i < 32; i++) if (m_stat[i] && m_en[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a >> 2)
      0: return m_stat;
      1: return m_stat & m_en;
      2: return m_en;
      6: return m_vec();
      7: return {30'd0, m_mst};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a >> 2)
      0, 2, 7: return "R1";
      1: return "R2";
      6: return "R3";
      3, 4, 5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit we, logic [7:0] a, logic [31:0] d, logic [31:0] s);
    logic [31:0] cap;
    int w;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; src_in = s;
    #1;
    chk(tag_of(a), bus_rdata, m_read(a));
    chk("R4", {31'd0, irq_out}, {31'd0, m_mst[0] && ((m_stat & m_en) != 0)});
    w = int'(a >> 2);
    cap = 0;
    for (int i = 0; i < 32; i++)
      if (m_mst[1] && s[i] && (!EDGE[i] || !m_srcq[i])) cap[i] = 1;
    if (we && w == 0 && !m_mst[1]) m_stat = d;
    else if (we && w == 3) m_stat = (m_stat & ~d) | cap;
    else m_stat = m_stat | cap;
    if (we && w == 2) m_en = d;
    if (we && w == 4) m_en = m_en | d;
    if (we && w == 5) m_en = m_en & ~d;
    if (we && w == 7) m_mst = d[1:0];
    m_srcq = s;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] s);
    step(0, a, 0, s);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    @(negedge clk); #1;
    chk("R11", bus_rdata, 32'd0);
    bus_addr = 8'h18; #1;
    chk("R11", bus_rdata, 32'hFFFF_FFFF);
    chk("R11", {31'd0, irq_out}, 32'd0);
    rd(8'h00, 0); rd(8'h08, 0); rd(8'h1C, 0); rd(8'h18, 0);
    // R8 set enable, then master on
    step(1, 8'h10, 32'h00F0_00F0, 0);
    step(1, 8'h1C, 32'h3, 0);
    rd(8'h08, 0);
    // R6 level source 5 high: captured, R3 vector 5
    step(0, 8'h18, 0, 32'h0000_0020);
    rd(8'h18, 32'h0000_0020);
    rd(8'h04, 32'h0000_0020);
    // R7 ack while still high: level recaptured
    step(1, 8'h0C, 32'h0000_0020, 32'h0000_0020);
    rd(8'h00, 0);
    step(1, 8'h0C, 32'hFFFF_FFFF, 0);
    rd(8'h00, 0);
    // R6 edge source 20: one capture, held high, ack stays cleared
    rd(8'h00, 32'h0010_0000);
    rd(8'h18, 32'h0010_0000);
    step(1, 8'h0C, 32'h0010_0000, 32'h0010_0000);
    rd(8'h00, 32'h0010_0000);
    rd(8'h00, 0);
    rd(8'h00, 32'h0010_0000);
    // R8 clear enable
    step(1, 8'h14, 32'h0010_0000, 32'h0010_0000);
    rd(8'h04, 0); rd(8'h18, 0);
    // R9 blocked status write; writes to pending/vector ignored
    step(1, 8'h00, 32'h0000_0001, 0);
    rd(8'h00, 0);
    step(1, 8'h04, 32'h1234_5678, 0);
    step(1, 8'h18, 32'h0, 0);
    rd(8'h0C, 0); rd(8'h10, 0); rd(8'h14, 0);
    // R5 capture off: sources ignored, software loads status
    step(1, 8'h1C, 32'h1, 0);
    step(1, 8'h0C, 32'hFFFF_FFFF, 0);
    rd(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0);
    step(1, 8'h00, 32'h0000_0040, 0);
    rd(8'h18, 0);
    // R4 output gate off
    step(1, 8'h1C, 32'h0, 0);
    rd(8'h04, 0);
    step(1, 8'h08, 32'hFFFF_FFFF, 0);
    rd(8'h18, 0);
    // R10 out of range
    step(1, 8'h20, 32'hFFFF_FFFF, 0);
    step(1, 8'hFC, 32'hFFFF_FFFF, 0);
    rd(8'h21, 0);
    rd(8'h1F, 0);
    // mixed stream
    lf = 32'hACE1_2345;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      s = lf & {lf[15:0], lf[31:16]};
      step(lf[3] & lf[7], {lf[13:12] == 0 ? 2'b01 : 2'b00, lf[11:8], 2'b00},
           {lf[7:0], lf[31:8]}, s);
    end
    rd(8'h00, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule